// File: doc/BRIEF.md
# Windowed Special-Function Register Bank

This block holds a small set of byte-wide control and status registers in the address range 00H to 17H. How an address is decoded depends on a window register at 14H, and it also depends on whether the access is a read or a write. In the base window, a read at an address can return a status byte while a write at that same address loads a control byte. A swap window reverses these paths so that software can read the controls back and can load the status bytes. A third window exposes extra control registers at some of the same addresses.

Software reaches the block over a synchronous byte bus with separate read and write strobes. Read data is registered and changes only after a read. Hardware sets status bits through per-register set vectors, which are ORed in every cycle. Two of the status registers clear themselves when they are read through the base window. Control values drive the output ports. The peripherals that use these controls and raise these events are outside the block.

Top module: `sfrwin_bank`

## Requirements
- R1: The window register at address 14H can be written and read back in every window. It drives `win_q`, and its reset value is 0.
- R2: In the base window, reads at 15H, 16H and 17H return status 0, status 1 and status 2. Writes at 15H, 16H and 17H load control 0, control 1 and PWM control 0, and a write at 0BH loads control 2.
- R3: In the swap window (window value 15), reads at 15H, 16H, 17H and 0BH return control 0, control 1, PWM control 0 and control 2. Writes at 15H, 16H and 17H load status 0, status 1 and status 2.
- R4: In the extra window (window value 1), 0CH reads and writes control 3, 16H reads and writes PWM control 1, and 17H reads and writes PWM control 2.
- R5: Addresses 00H and 01H read as 0 in every window. Writes to them change no register.
- R6: Any other address or direction that is not mapped in the current window reads as 0, and a write there changes nothing. Examples are a base-window read of 0BH, an extra-window read of 15H, and a write to 05H.
- R7: A base-window read of 16H returns the value that status 1 held before the read. It then clears bits 5:0 of status 1 and leaves bits 7:6 unchanged.
- R8: A base-window read of 17H returns the value that status 2 held before the read. It then clears the whole register.
- R9: Control 2 stores bits 6:0 of the written byte, and bit 7 reads as 1 when the register is read.
- R10: Control 3 keeps only bits 0, 2 and 3 of the written byte, and stores its other bits as 0.
- R11: A bit raised on a status set input is present in that register the next cycle. This holds even when a clearing read falls in the same cycle.
- R12: Reset clears every register and the read data. A window value other than 1 or 15 decodes exactly as window 0 does.
- R13: `rdata` updates on the clock edge where `rd_en` is high, showing the value read at that edge, and holds in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| st0_set | input | 8 | Set bits of status 0 |
| st1_set | input | 8 | Set bits of status 1 |
| st2_set | input | 8 | Set bits of status 2 |
| win_q | output | 8 | Window register |
| ctl0_q | output | 8 | Control 0 |
| ctl1_q | output | 8 | Control 1 |
| ctl2_q | output | 8 | Control 2 (stored bit 7 is 0) |
| ctl3_q | output | 8 | Control 3 |
| pwm0_q | output | 8 | PWM control 0 |
| pwm1_q | output | 8 | PWM control 1 |
| pwm2_q | output | 8 | PWM control 2 |

## Verification
The status assertions assume that no write to a status register lands in the same cycle as a clearing read of that register. The decode makes this true, because status registers are written only in the swap window and cleared only in the base window. The clear and keep properties also assume that the set vector is zero in the cycle they inspect. The stimulus therefore raises set bits in separate cycles, except in the single case aimed at R11. The bench drives each input at the falling edge and keeps addresses within 00H to 17H, so every access is either decoded or deliberately unmapped.

// File: rtl/sfrwin_pkg.sv
package sfrwin_pkg;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int NCTL = 8;
  localparam int NST  = 3;
  localparam int IW   = $clog2(NCTL);

  localparam int C_CTL0 = 0;
  localparam int C_CTL1 = 1;
  localparam int C_CTL2 = 2;
  localparam int C_CTL3 = 3;
  localparam int C_PWM0 = 4;
  localparam int C_PWM1 = 5;
  localparam int C_PWM2 = 6;
  localparam int C_WIN  = 7;

  localparam int S_ST0 = 0;
  localparam int S_ST1 = 1;
  localparam int S_ST2 = 2;

  localparam logic [AW-1:0] A_WIN = 5'h14;
  localparam logic [AW-1:0] A_C2  = 5'h0B;
  localparam logic [AW-1:0] A_C3  = 5'h0C;
  localparam logic [AW-1:0] A_X0  = 5'h15;
  localparam logic [AW-1:0] A_X1  = 5'h16;
  localparam logic [AW-1:0] A_X2  = 5'h17;

  typedef enum logic [1:0] {WM_BASE, WM_ALT, WM_SWAP} wmode_e;
  typedef enum logic [1:0] {K_NONE, K_CTL, K_ST} kind_e;
  typedef struct packed {
    kind_e          kind;
    logic [IW-1:0]  idx;
  } tgt_t;

  function automatic wmode_e win_mode(input logic [DW-1:0] w);
    if (w == DW'(1))       return WM_ALT;
    else if (w == DW'(15)) return WM_SWAP;
    else                   return WM_BASE;
  endfunction

  function automatic tgt_t mk(input kind_e k, input int i);
    tgt_t t;
    t.kind = k;
    t.idx  = IW'(i);
    return t;
  endfunction

  // Direction-dependent decode of one access.
  function automatic tgt_t decode(input wmode_e m, input logic [AW-1:0] a,
                                  input logic is_wr);
    tgt_t t = mk(K_NONE, 0);
    if (a == A_WIN) return mk(K_CTL, C_WIN);
    case (m)
      WM_BASE: begin
        if (a == A_X0)      t = is_wr ? mk(K_CTL, C_CTL0) : mk(K_ST, S_ST0);
        else if (a == A_X1) t = is_wr ? mk(K_CTL, C_CTL1) : mk(K_ST, S_ST1);
        else if (a == A_X2) t = is_wr ? mk(K_CTL, C_PWM0) : mk(K_ST, S_ST2);
        else if (a == A_C2 && is_wr) t = mk(K_CTL, C_CTL2);
      end
      WM_SWAP: begin
        if (a == A_X0)      t = is_wr ? mk(K_ST, S_ST0) : mk(K_CTL, C_CTL0);
        else if (a == A_X1) t = is_wr ? mk(K_ST, S_ST1) : mk(K_CTL, C_CTL1);
        else if (a == A_X2) t = is_wr ? mk(K_ST, S_ST2) : mk(K_CTL, C_PWM0);
        else if (a == A_C2) t = mk(K_CTL, C_CTL2);
      end
      default: begin
        if (a == A_C3)      t = mk(K_CTL, C_CTL3);
        else if (a == A_X1) t = mk(K_CTL, C_PWM1);
        else if (a == A_X2) t = mk(K_CTL, C_PWM2);
      end
    endcase
    return t;
  endfunction

  function automatic logic [DW-1:0] ctl_keep(input int i);
    case (i)
      C_CTL2:  return 8'h7F;
      C_CTL3:  return 8'h0D;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctl_force(input int i);
    return (i == C_CTL2) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [DW-1:0] st_clr(input int i);
    case (i)
      S_ST1:   return 8'h3F;
      S_ST2:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfrwin_decode.sv
module sfrwin_decode
  import sfrwin_pkg::*;
(
  input  logic [DW-1:0] win_q,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [NCTL-1:0] wr_ctl,
  output logic [NST-1:0]  wr_st,
  output logic [NST-1:0]  clr_st,
  output tgt_t            rd_tgt
);
  wmode_e mode;
  tgt_t   wr_tgt;

  assign mode   = win_mode(win_q);
  assign wr_tgt = decode(mode, addr, 1'b1);
  assign rd_tgt = decode(mode, addr, 1'b0);

  for (genvar g = 0; g < NCTL; g++) begin : g_wc
    assign wr_ctl[g] = wr_en && wr_tgt.kind == K_CTL && wr_tgt.idx == IW'(g);
  end
  for (genvar g = 0; g < NST; g++) begin : g_ws
    assign wr_st[g]  = wr_en && wr_tgt.kind == K_ST && wr_tgt.idx == IW'(g);
    assign clr_st[g] = rd_en && rd_tgt.kind == K_ST && rd_tgt.idx == IW'(g)
                       && st_clr(g) != '0;
  end
endmodule

// File: rtl/sfrwin_ctl.sv
module sfrwin_ctl
  import sfrwin_pkg::*;
#(
  parameter logic [DW-1:0] KEEP = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wd & KEEP;
  end

  // R5, R6: a register without its own write strobe does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/sfrwin_stat.sv
module sfrwin_stat
  import sfrwin_pkg::*;
#(
  parameter logic [DW-1:0] CLR = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wd,
  input  logic          clr,
  input  logic [DW-1:0] set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] base;
  logic [DW-1:0] cmask;

  assign base  = wr ? wd : q;
  assign cmask = clr ? CLR : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (base & ~cmask) | set;
  end

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr && set == '0) |=> ((q & CLR) == '0));
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr && set == '0) |=> ((q & ~CLR) == ($past(q) & ~CLR)));
endmodule

// File: rtl/sfrwin_bank.sv
module sfrwin_bank
  import sfrwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic [7:0]    st0_set,
  input  logic [7:0]    st1_set,
  input  logic [7:0]    st2_set,
  output logic [7:0]    win_q,
  output logic [7:0]    ctl0_q,
  output logic [7:0]    ctl1_q,
  output logic [7:0]    ctl2_q,
  output logic [7:0]    ctl3_q,
  output logic [7:0]    pwm0_q,
  output logic [7:0]    pwm1_q,
  output logic [7:0]    pwm2_q
);
  logic [NCTL-1:0] wr_ctl;
  logic [NST-1:0]  wr_st;
  logic [NST-1:0]  clr_st;
  tgt_t            rd_tgt;
  logic [DW-1:0]   ctl_q  [NCTL];
  logic [DW-1:0]   st_q   [NST];
  logic [DW-1:0]   st_set [NST];
  logic [DW-1:0]   rd_mux;

  assign st_set[S_ST0] = st0_set;
  assign st_set[S_ST1] = st1_set;
  assign st_set[S_ST2] = st2_set;

  sfrwin_decode u_dec (
    .win_q (ctl_q[C_WIN]),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wr_ctl(wr_ctl),
    .wr_st (wr_st),
    .clr_st(clr_st),
    .rd_tgt(rd_tgt)
  );

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    sfrwin_ctl #(.KEEP(ctl_keep(g))) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctl[g]), .wd(wdata), .q(ctl_q[g])
    );
  end

  for (genvar g = 0; g < NST; g++) begin : g_st
    sfrwin_stat #(.CLR(st_clr(g))) u_st (
      .clk(clk), .rst_n(rst_n), .wr(wr_st[g]), .wd(wdata),
      .clr(clr_st[g]), .set(st_set[g]), .q(st_q[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCTL; i++)
      if (rd_tgt.kind == K_CTL && rd_tgt.idx == IW'(i))
        rd_mux = ctl_q[i] | ctl_force(i);
    for (int i = 0; i < NST; i++)
      if (rd_tgt.kind == K_ST && rd_tgt.idx == IW'(i))
        rd_mux = st_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign win_q  = ctl_q[C_WIN];
  assign ctl0_q = ctl_q[C_CTL0];
  assign ctl1_q = ctl_q[C_CTL1];
  assign ctl2_q = ctl_q[C_CTL2];
  assign ctl3_q = ctl_q[C_CTL3];
  assign pwm0_q = ctl_q[C_PWM0];
  assign pwm1_q = ctl_q[C_PWM1];
  assign pwm2_q = ctl_q[C_PWM2];

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr <= 5'h01) |=> (rdata == '0));
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  p_ctl2_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'h0B && win_q == 8'd15) |=> rdata[7]);
endmodule

// File: tb/tb_sfrwin_bank.sv
module tb_sfrwin_bank;
  logic clk = 0, rst_n = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, st0_set = 0, st1_set = 0, st2_set = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rdata, win_q, ctl0_q, ctl1_q, ctl2_q, ctl3_q, pwm0_q, pwm1_q, pwm2_q;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_win, m_c0, m_c1, m_c2, m_c3, m_p0, m_p1, m_p2, m_s0, m_s1, m_s2, m_rd;

  always #2 clk = ~clk;

  sfrwin_bank dut (.*);

  function automatic int wsel();
    if (m_win == 8'd1) return 1;
    if (m_win == 8'd15) return 15;
    return 0;
  endfunction

  function automatic logic [7:0] ref_read(input logic [4:0] a);
    int w = wsel();
    if (a == 5'h14) return m_win;
    if (w == 0) begin
      if (a == 5'h15) return m_s0;
      if (a == 5'h16) return m_s1;
      if (a == 5'h17) return m_s2;
    end else if (w == 15) begin
      if (a == 5'h15) return m_c0;
      if (a == 5'h16) return m_c1;
      if (a == 5'h17) return m_p0;
      if (a == 5'h0B) return m_c2 | 8'h80;
    end else begin
      if (a == 5'h0C) return m_c3;
      if (a == 5'h16) return m_p1;
      if (a == 5'h17) return m_p2;
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    {m_win, m_c0, m_c1, m_c2, m_c3, m_p0, m_p1, m_p2} = '0;
    {m_s0, m_s1, m_s2, m_rd} = '0;
  endtask

  task automatic compare(input string tag);
    logic [63:0] act, exp;
    act = {win_q, ctl0_q, ctl1_q, ctl2_q, ctl3_q, pwm0_q, pwm1_q, pwm2_q};
    exp = {m_win, m_c0, m_c1, m_c2, m_c3, m_p0, m_p1, m_p2};
    checks++;
    if (rdata !== m_rd || act !== exp) begin
      failures++;
      $display("FAIL %s rdata=%h exp=%h regs=%h exp=%h", tag, rdata, m_rd, act, exp);
    end
  endtask

  // One bus cycle; starts and ends at a falling edge.
  task automatic step(input logic [4:0] a, input logic [7:0] d, input logic we,
                      input logic re, input logic [7:0] s0, input logic [7:0] s1,
                      input logic [7:0] s2, input string tag);
    int w = wsel();
    addr = a; wdata = d; wr_en = we; rd_en = re;
    st0_set = s0; st1_set = s1; st2_set = s2;
    if (re) begin
      m_rd = ref_read(a);
      if (w == 0 && a == 5'h16) m_s1 = m_s1 & 8'hC0;
      if (w == 0 && a == 5'h17) m_s2 = 8'h00;
    end
    if (we) begin
      if (a == 5'h14) m_win = d;
      else if (w == 0) begin
        if (a == 5'h15) m_c0 = d;
        if (a == 5'h16) m_c1 = d;
        if (a == 5'h17) m_p0 = d;
        if (a == 5'h0B) m_c2 = d & 8'h7F;
      end else if (w == 15) begin
        if (a == 5'h15) m_s0 = d;
        if (a == 5'h16) m_s1 = d;
        if (a == 5'h17) m_s2 = d;
        if (a == 5'h0B) m_c2 = d & 8'h7F;
      end else begin
        if (a == 5'h0C) m_c3 = d & 8'h0D;
        if (a == 5'h16) m_p1 = d;
        if (a == 5'h17) m_p2 = d;
      end
    end
    m_s0 |= s0; m_s1 |= s1; m_s2 |= s2;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; st0_set = 0; st1_set = 0; st2_set = 0;
    compare(tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
    step(a, d, 1, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    step(a, 0, 0, 1, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R12 reset");
    // R1 window register in several windows
    wr(5'h14, 8'h5A, "R1"); rd(5'h14, "R1");
    // R12 window 5AH behaves as base window
    step(0, 0, 0, 0, 8'h81, 0, 0, "R12"); rd(5'h15, "R12 base decode");
    wr(5'h14, 8'h00, "R1");
    // R2 base window writes and reads
    wr(5'h15, 8'hA5, "R2"); wr(5'h16, 8'h3C, "R2");
    wr(5'h17, 8'h77, "R2"); wr(5'h0B, 8'hFF, "R2 R9");
    step(0, 0, 0, 0, 8'h02, 8'hFF, 8'h0F, "R11 set");
    rd(5'h15, "R2"); rd(5'h15, "R2 no clear");
    // R7 partial clear, R8 full clear
    rd(5'h16, "R7"); rd(5'h16, "R7 after");
    rd(5'h17, "R8"); rd(5'h17, "R8 after");
    // R11 set in the clearing cycle
    step(5'h16, 0, 0, 1, 0, 8'h01, 0, "R11"); rd(5'h16, "R11 kept");
    step(5'h17, 0, 0, 1, 0, 0, 8'h40, "R11"); rd(5'h17, "R11 kept");
    // R13 hold
    step(0, 0, 0, 0, 0, 0, 0, "R13"); step(5'h15, 0, 0, 0, 0, 0, 0, "R13");
    // R3 swap window
    wr(5'h14, 8'd15, "R1");
    rd(5'h15, "R3"); rd(5'h16, "R3"); rd(5'h17, "R3"); rd(5'h0B, "R3 R9");
    wr(5'h15, 8'h11, "R3"); wr(5'h16, 8'hE2, "R3"); wr(5'h17, 8'h33, "R3");
    wr(5'h0B, 8'h00, "R9"); rd(5'h0B, "R9 msb");
    rd(5'h14, "R1");
    wr(5'h14, 8'h00, "R1");
    rd(5'h15, "R3 status"); rd(5'h16, "R3 R7"); rd(5'h16, "R7");
    rd(5'h17, "R3 R8"); rd(5'h0B, "R6 base 0B");
    // R4, R10 extra window
    wr(5'h14, 8'd1, "R1");
    wr(5'h0C, 8'hFF, "R10"); rd(5'h0C, "R10"); wr(5'h0C, 8'hF2, "R10"); rd(5'h0C, "R10");
    wr(5'h16, 8'h9A, "R4"); wr(5'h17, 8'hBC, "R4");
    rd(5'h16, "R4"); rd(5'h17, "R4"); rd(5'h15, "R6 alt 15"); rd(5'h14, "R1");
    // R5, R6 in each window
    for (int k = 0; k < 3; k++) begin
      logic [7:0] wv = (k == 0) ? 8'd0 : (k == 1) ? 8'd1 : 8'd15;
      wr(5'h14, wv, "R1");
      wr(5'h00, 8'hFF, "R5"); wr(5'h01, 8'hFF, "R5");
      rd(5'h00, "R5"); rd(5'h01, "R5");
      wr(5'h05, 8'hEE, "R6"); rd(5'h05, "R6"); rd(5'h10, "R6");
    end
    // R12 reset mid-run
    rst_n = 0; @(posedge clk); @(negedge clk); model_reset();
    rst_n = 1; compare("R12 reset");
    rd(5'h16, "R12"); rd(5'h14, "R12");
    done = 1;
    summary();
  end
endmodule